// File: doc/BRIEF.md
# Boot-Load Bus Access Sequencer

This block is a bus master that performs a fixed two-phase boot transaction on a shared, arbitrated bus. A local load request arms it. When the arbiter then sends a priority pulse, the block takes the bus. It runs a direct write that drives a fixed address and a fixed data word, and it waits for the addressed memory to report completion. After the memory finishes, the block raises a one-cycle interrupt-start indication and holds a service request to the arbiter. Once the arbiter selects it and sends a second priority pulse, the block runs a second bus cycle with a slave acknowledge, and then it returns to idle.

The priority, select and done inputs arrive without a common clock, so each one passes through a synchronizer chain of parameterized depth. Edges are detected on the synchronized levels. The delay from bus-online to strobe comes from the clock period and the required delay in nanoseconds. With the defaults (5 ns clock, 50 ns delay) this is 10 cycles. The load address, the data word and both bus widths are parameters.

Top module: `boot_bus_seq`

## Requirements
- R1: While reset is high and after it is released, online_n, ack_n, req_n, ack_clk_n, bus_end_n and held_online_n are high. online, strobe, int_start, addr_oe, data_oe, busy and seq_done are low, and addr_out and data_out are zero.
- R2: The first bus cycle starts only on a rising edge of the priority input while a load is pending. A priority pulse with no load pending leaves online low.
- R3: In the first bus cycle online goes high and online_n goes low together.
- R4: In each of the two bus cycles, strobe rises exactly STROBE_CYCLES clock edges after online rises. STROBE_CYCLES is ceil(STROBE_DELAY_NS / CLK_PERIOD_NS), which is 10 by default.
- R5: addr_oe and data_oe are high only while the first bus cycle holds the bus. During that time addr_out is LOAD_ADDR (0x0006) and data_out is LOAD_DATA (0xFB00). At every other time both are zero.
- R6: A rising edge of mem_done during the first cycle drives ack_clk_n and bus_end_n low. Both stay low until mem_done falls.
- R7: A falling edge of mem_done releases online, ack_clk_n, bus_end_n and the enables, and it pulses int_start high for exactly one cycle. req_n goes low on the following cycle.
- R8: req_n stays low while the block waits for select. A priority pulse that arrives before select_n is seen low does not start the second cycle.
- R9: After select_n is low, a priority rising edge drives ack_n low and online high for the second cycle. The enables stay off.
- R10: The second-cycle strobe edge returns ack_n and req_n high and drives held_online_n low for that one cycle. On the next cycle the block is idle, and seq_done pulses for one cycle.
- R11: A load request while busy is high is ignored. After the sequence ends, busy is low and a priority pulse does not start a cycle.
- R12: Each asynchronous input takes effect on the third rising clock edge after it changes (two synchronizer stages plus the edge detector). busy is high from the edge after a load request until the sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| load_req | input | 1 | Synchronous boot-load request |
| prio_in | input | 1 | Asynchronous priority pulse from the arbiter |
| select_n | input | 1 | Asynchronous select from the arbiter, active low |
| mem_done | input | 1 | Asynchronous completion from the addressed memory |
| online | output | 1 | Bus-online, active high |
| online_n | output | 1 | Bus-online, active low |
| strobe | output | 1 | Bus strobe |
| ack_n | output | 1 | Slave acknowledge for the second cycle, active low |
| req_n | output | 1 | Service request to the arbiter, active low |
| int_start | output | 1 | One-cycle interrupt-start indication |
| ack_clk_n | output | 1 | Acknowledge clock, active low |
| bus_end_n | output | 1 | End-of-cycle indication to the bus, active low |
| held_online_n | output | 1 | Held-online indication, active low |
| addr_oe | output | 1 | Address line output enable |
| data_oe | output | 1 | Data line output enable |
| addr_out | output | ADDR_W | Address driven in the first cycle |
| data_out | output | DATA_W | Data driven in the first cycle |
| busy | output | 1 | A sequence is armed or in progress |
| seq_done | output | 1 | One-cycle pulse when the sequence completes |

## Verification
The assertions check four relations on every cycle. The output enables never appear without online. The acknowledge clock appears only while the bus is held. The online-to-strobe distance is checked in both phases by a counter, so no $past depth depends on a parameter. int_start and seq_done must be single-cycle pulses, and seq_done must follow the held-online cycle. Other behaviour shows only in the bench scenarios: ignored priority pulses and ignored load requests, the exact three-edge synchronizer latency, the fixed address and data values, and the order from done to interrupt-start to request. The bench sweeps the whole sequence with several idle gaps between the events and computes each expected edge from the parameters.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_P1_ON,
      ST_P1_STB,
      ST_P1_DONE,
      ST_P2_INT,
      ST_P2_REQ,
      ST_P2_WAIT,
      ST_P2_ON,
      ST_P2_STB
   } seq_state_t;

   function automatic logic in_first_cycle(input seq_state_t s);
      return (s == ST_P1_ON) || (s == ST_P1_STB) || (s == ST_P1_DONE);
   endfunction

   function automatic logic bus_online(input seq_state_t s);
      return in_first_cycle(s) || (s == ST_P2_ON) || (s == ST_P2_STB);
   endfunction

endpackage

// File: rtl/bus_in_sync.sv
module bus_in_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_depth
      $error("bus_in_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) stg[0] <= RST_VAL;
      else     stg[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) stg[i] <= RST_VAL;
         else     stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/bus_strobe_timer.sv
module bus_strobe_timer #(
   parameter int CYCLES = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic expired
);

   localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("bus_strobe_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt;

   assign expired = run && (cnt == CW'(CYCLES - 1));

   always_ff @(posedge clk) begin
      if (rst || !run)  cnt <= '0;
      else if (!expired) cnt <= cnt + 1'b1;
   end

   assert_timer_bound_R4: assert property (@(posedge clk) disable iff (rst)
      cnt <= CW'(CYCLES - 1));

endmodule

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
   import boot_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       load_req,
   input  logic       prio_s,
   input  logic       sel_n_s,
   input  logic       done_s,
   input  logic       tmr_exp,
   output seq_state_t state,
   output logic       busy,
   output logic       seq_done
);

   seq_state_t nxt;
   logic       pend;
   logic       prio_q;
   logic       done_q;
   logic       prio_rise;
   logic       done_rise;
   logic       done_fall;

   assign prio_rise = prio_s && !prio_q;
   assign done_rise = done_s && !done_q;
   assign done_fall = !done_s && done_q;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:    if (pend && prio_rise) nxt = ST_P1_ON;
         ST_P1_ON:   if (tmr_exp)           nxt = ST_P1_STB;
         ST_P1_STB:  if (done_rise)         nxt = ST_P1_DONE;
         ST_P1_DONE: if (done_fall)         nxt = ST_P2_INT;
         ST_P2_INT:                         nxt = ST_P2_REQ;
         ST_P2_REQ:  if (!sel_n_s)          nxt = ST_P2_WAIT;
         ST_P2_WAIT: if (prio_rise)         nxt = ST_P2_ON;
         ST_P2_ON:   if (tmr_exp)           nxt = ST_P2_STB;
         ST_P2_STB:                         nxt = ST_IDLE;
         default:                           nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         pend     <= 1'b0;
         prio_q   <= 1'b0;
         done_q   <= 1'b0;
         seq_done <= 1'b0;
      end else begin
         state    <= nxt;
         prio_q   <= prio_s;
         done_q   <= done_s;
         seq_done <= (state == ST_P2_STB);
         if (nxt == ST_P1_ON)                pend <= 1'b0;
         else if (state == ST_IDLE && load_req) pend <= 1'b1;
      end
   end

   assign busy = pend || (state != ST_IDLE);

   assert_seq_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
      seq_done |=> !seq_done);

   assert_no_start_unarmed_R2: assert property (@(posedge clk) disable iff (rst)
      (state == ST_IDLE && !pend) |=> (state == ST_IDLE));

endmodule

// File: rtl/boot_bus_seq.sv
module boot_bus_seq
   import boot_seq_pkg::*;
#(
   parameter int              CLK_PERIOD_NS   = 5,
   parameter int              STROBE_DELAY_NS = 50,
   parameter int              SYNC_STAGES     = 2,
   parameter int              ADDR_W          = 16,
   parameter int              DATA_W          = 16,
   parameter logic [ADDR_W-1:0] LOAD_ADDR     = 16'h0006,
   parameter logic [DATA_W-1:0] LOAD_DATA     = 16'hFB00
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_req,
   input  logic              prio_in,
   input  logic              select_n,
   input  logic              mem_done,
   output logic              online,
   output logic              online_n,
   output logic              strobe,
   output logic              ack_n,
   output logic              req_n,
   output logic              int_start,
   output logic              ack_clk_n,
   output logic              bus_end_n,
   output logic              held_online_n,
   output logic              addr_oe,
   output logic              data_oe,
   output logic [ADDR_W-1:0] addr_out,
   output logic [DATA_W-1:0] data_out,
   output logic              busy,
   output logic              seq_done
);

   localparam int STROBE_CYCLES = (STROBE_DELAY_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
   localparam int NSYNC         = 3;
   localparam logic [NSYNC-1:0] SYNC_IDLE = 3'b010;   // {done, select_n, prio}

   if (CLK_PERIOD_NS < 1 || STROBE_DELAY_NS < CLK_PERIOD_NS) begin : g_bad_timing
      $error("boot_bus_seq: strobe delay must cover at least one clock period");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("boot_bus_seq: bus widths must be positive");
   end

   logic [NSYNC-1:0] async_in;
   logic [NSYNC-1:0] sync_out;
   seq_state_t       state;
   logic             tmr_run;
   logic             tmr_exp;
   logic             first_cyc;

   assign async_in = {mem_done, select_n, prio_in};

   bus_in_sync #(
      .W       (NSYNC),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_IDLE)
   ) i_sync (
      .clk (clk),
      .rst (rst),
      .d   (async_in),
      .q   (sync_out)
   );

   assign tmr_run = (state == ST_P1_ON) || (state == ST_P2_ON);

   bus_strobe_timer #(
      .CYCLES (STROBE_CYCLES)
   ) i_timer (
      .clk     (clk),
      .rst     (rst),
      .run     (tmr_run),
      .expired (tmr_exp)
   );

   bus_seq_fsm i_fsm (
      .clk      (clk),
      .rst      (rst),
      .load_req (load_req),
      .prio_s   (sync_out[0]),
      .sel_n_s  (sync_out[1]),
      .done_s   (sync_out[2]),
      .tmr_exp  (tmr_exp),
      .state    (state),
      .busy     (busy),
      .seq_done (seq_done)
   );

   // Moore output decode
   assign first_cyc     = in_first_cycle(state);
   assign online        = bus_online(state);
   assign online_n      = !online;
   assign strobe        = (state == ST_P1_STB) || (state == ST_P2_STB);
   assign ack_n         = (state != ST_P2_ON);
   assign req_n         = !((state == ST_P2_REQ) || (state == ST_P2_WAIT) || (state == ST_P2_ON));
   assign int_start     = (state == ST_P2_INT);
   assign ack_clk_n     = (state != ST_P1_DONE);
   assign bus_end_n     = (state != ST_P1_DONE);
   assign held_online_n = (state != ST_P2_STB);
   assign addr_oe       = first_cyc;
   assign data_oe       = first_cyc;
   assign addr_out      = first_cyc ? LOAD_ADDR : '0;
   assign data_out      = first_cyc ? LOAD_DATA : '0;

   // Checker: cycles since online rose, saturating
   localparam int CHK_W = $clog2(STROBE_CYCLES + 2);
   logic [CHK_W-1:0] chk_on_cnt;

   always_ff @(posedge clk) begin
      if (rst || !online)                              chk_on_cnt <= '0;
      else if (chk_on_cnt != CHK_W'(STROBE_CYCLES + 1)) chk_on_cnt <= chk_on_cnt + 1'b1;
   end

   assert_strobe_delay_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(strobe) |-> (chk_on_cnt == CHK_W'(STROBE_CYCLES)));

   assert_oe_needs_online_R5: assert property (@(posedge clk) disable iff (rst)
      (addr_oe || data_oe) |-> online);

   assert_ackclk_on_bus_R6: assert property (@(posedge clk) disable iff (rst)
      !ack_clk_n |-> (online && !strobe));

   assert_int_pulse_R7: assert property (@(posedge clk) disable iff (rst)
      int_start |=> (!int_start && !req_n));

   assert_done_after_hold_R10: assert property (@(posedge clk) disable iff (rst)
      seq_done |-> ($past(!held_online_n) && !online && req_n));

endmodule

// File: tb/test_boot_bus_seq.sv
`timescale 1ns/1ps
module test_boot_bus_seq;

   localparam int D = 50 / 5;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        load_req = 1'b0;
   logic        prio_in = 1'b0;
   logic        select_n = 1'b1;
   logic        mem_done = 1'b0;
   logic        online, online_n, strobe, ack_n, req_n, int_start;
   logic        ack_clk_n, bus_end_n, held_online_n, addr_oe, data_oe;
   logic [15:0] addr_out, data_out;
   logic        busy, seq_done;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   boot_bus_seq i_boot_bus_seq (
      .clk(clk), .rst(rst), .load_req(load_req), .prio_in(prio_in),
      .select_n(select_n), .mem_done(mem_done), .online(online),
      .online_n(online_n), .strobe(strobe), .ack_n(ack_n), .req_n(req_n),
      .int_start(int_start), .ack_clk_n(ack_clk_n), .bus_end_n(bus_end_n),
      .held_online_n(held_online_n), .addr_oe(addr_oe), .data_oe(data_oe),
      .addr_out(addr_out), .data_out(data_out), .busy(busy), .seq_done(seq_done)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   initial begin
      tick(3);
      rst = 1'b0;
      // R1: idle after reset
      chk("R1", "online",    32'(online), 0);
      chk("R1", "online_n",  32'(online_n), 1);
      chk("R1", "strobes",   32'({ack_n, req_n, ack_clk_n, bus_end_n, held_online_n}), 32'h1F);
      chk("R1", "pulses",    32'({strobe, int_start, addr_oe, data_oe, busy, seq_done}), 0);
      chk("R1", "buses",     32'({addr_out, data_out}), 0);

      // R2: priority pulse without a pending load
      prio_in = 1'b1; tick(2); prio_in = 1'b0; tick(4);
      chk("R2", "online unarmed", 32'(online), 0);

      for (int gap = 0; gap < 4; gap++) begin
         load_req = 1'b1; tick(1); load_req = 1'b0;
         chk("R12", "busy after load", 32'(busy), 1);
         tick(gap);
         prio_in = 1'b1; tick(2);
         chk("R12", "online before 3rd edge", 32'(online), 0);
         prio_in = 1'b0; tick(1);
         chk("R3", "online", 32'(online), 1);
         chk("R3", "online_n", 32'(online_n), 0);
         chk("R5", "enables", 32'({addr_oe, data_oe}), 32'h3);
         chk("R5", "addr", 32'(addr_out), 32'h0006);
         chk("R5", "data", 32'(data_out), 32'hFB00);
         for (int k = 1; k <= D; k++) begin
            tick(1);
            chk("R4", "strobe phase 1", 32'(strobe), 32'(k == D));
         end
         // R11: load request while busy
         load_req = 1'b1; tick(1); load_req = 1'b0;
         chk("R11", "strobe held", 32'(strobe), 1);
         tick(gap);
         mem_done = 1'b1; tick(2);
         chk("R12", "ack_clk before 3rd edge", 32'(ack_clk_n), 1);
         tick(1);
         chk("R6", "ack_clk_n", 32'(ack_clk_n), 0);
         chk("R6", "bus_end_n", 32'(bus_end_n), 0);
         chk("R6", "online held", 32'(online), 1);
         tick(gap);
         chk("R6", "ack_clk_n held", 32'(ack_clk_n), 0);
         mem_done = 1'b0; tick(3);
         chk("R7", "int_start", 32'(int_start), 1);
         chk("R7", "released", 32'({online, addr_oe, data_oe}), 0);
         chk("R7", "ack_clk_n", 32'({ack_clk_n, bus_end_n}), 32'h3);
         chk("R5", "buses off", 32'({addr_out, data_out}), 0);
         tick(1);
         chk("R7", "int_start single", 32'(int_start), 0);
         chk("R7", "req_n", 32'(req_n), 0);
         // R8: priority before select
         prio_in = 1'b1; tick(2); prio_in = 1'b0; tick(4 + gap);
         chk("R8", "no early cycle", 32'(online), 0);
         chk("R8", "req_n held", 32'(req_n), 0);
         select_n = 1'b0; tick(4);
         prio_in = 1'b1; tick(2);
         chk("R12", "phase2 before 3rd edge", 32'(online), 0);
         prio_in = 1'b0; tick(1);
         chk("R9", "online", 32'(online), 1);
         chk("R9", "ack_n", 32'(ack_n), 0);
         chk("R9", "enables off", 32'({addr_oe, data_oe}), 0);
         for (int k = 1; k <= D; k++) begin
            tick(1);
            chk("R4", "strobe phase 2", 32'(strobe), 32'(k == D));
            chk("R10", "ack_n", 32'(ack_n), 32'(k == D));
            chk("R10", "req_n", 32'(req_n), 32'(k == D));
            chk("R10", "held_online_n", 32'(held_online_n), 32'(k != D));
         end
         tick(1);
         chk("R10", "strobe off", 32'({strobe, online}), 0);
         chk("R10", "seq_done", 32'(seq_done), 1);
         chk("R10", "busy", 32'(busy), 0);
         chk("R10", "held released", 32'(held_online_n), 1);
         select_n = 1'b1; tick(1);
         chk("R10", "seq_done single", 32'(seq_done), 0);
         // R11: the load request made while busy left nothing armed
         prio_in = 1'b1; tick(2); prio_in = 1'b0; tick(4);
         chk("R11", "no restart", 32'(online), 0);
         chk("R11", "not busy", 32'(busy), 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule